// File: doc/BRIEF.md
# Dual-Port Semaphore Latch Bank

This block keeps a small bank of hardware semaphores that two independent ports, left and right, use to reserve shared resources. Each port has a select, a write strobe, a read enable, a semaphore address and a data bus. A port asks for a semaphore by writing a zero on data bit 0 and gives it back by writing a one. If a port asks while the other side holds the semaphore, its request is remembered. Ownership then passes to it as soon as the holder releases.

Every semaphore keeps one request flag per side and one owner field. A port reads all zeros when it owns the semaphore and all ones when it does not. The value read is captured in a per-port output register and held there until that port's next read. When both sides ask for a free semaphore in the same clock cycle, the left side gets it and the right side's request stays pending.

The read side is a push-only stream. A read that is accepted in one cycle raises `*_rvalid` for the next cycle, and `*_rdata` holds the captured value until the next read. There is no ready input. Results cannot be held off, and no read is ever refused.

Top module: `dp_semaphore_bank`

## Requirements
- R1: The bank holds eight semaphores selected by a 3-bit address. A write or read at one address leaves the state seen at every other address unchanged.
- R2: Only write data bit 0 matters: 0 requests and 1 releases. Bits 7:1 are ignored, so 8'hFE requests and 8'h01 releases.
- R3: A request to a free semaphore grants it at once. The owner then reads 8'h00 at that address and the other port reads 8'hFF.
- R4: While one side owns a semaphore, a zero written by the other side does not take it away. The owner keeps reading 8'h00 and the other side keeps reading 8'hFF.
- R5: If the non-owner wrote a zero during the ownership, that side becomes owner in the same cycle the owner writes a one.
- R6: If the owner releases with no request pending from the other side, the semaphore becomes free and both ports read 8'hFF.
- R7: When both ports write a zero to a free semaphore in the same cycle, the left port obtains it and the right port's request stays pending.
- R8: A read (select high, write strobe low, read enable high) loads all eight bits of `*_rdata` with the semaphore value and raises `*_rvalid` for exactly the next cycle. `*_rdata` then holds that value until the port's next read, whatever the other port writes.
- R9: Writing a one to a semaphore that the port neither owns nor has requested has no effect. Writing a one while the port's own request is pending cancels that request.
- R10: A synchronous active-high reset frees every semaphore and clears all requests. It sets both `*_rdata` to 8'hFF and both `*_rvalid` to 0.
- R11: A read returns the state from before any write accepted in the same cycle, including a write from the opposite port. A read one cycle later returns the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left port select |
| l_we | input | 1 | Left write strobe (1 = write) |
| l_oe | input | 1 | Left read enable |
| l_addr | input | 3 | Left semaphore address |
| l_wdata | input | 8 | Left write data (bit 0 used) |
| l_rdata | output | 8 | Left registered read data |
| l_rvalid | output | 1 | Left read data valid pulse |
| r_sel | input | 1 | Right port select |
| r_we | input | 1 | Right write strobe (1 = write) |
| r_oe | input | 1 | Right read enable |
| r_addr | input | 3 | Right semaphore address |
| r_wdata | input | 8 | Right write data (bit 0 used) |
| r_rdata | output | 8 | Right registered read data |
| r_rvalid | output | 1 | Right read data valid pulse |

## Verification
Two functions of this block can land in the same cycle: a request from each side on one semaphore, and a read on one port against a write from the other port. The bench provokes the first by sweeping every pair of left/right operations (idle, request, release) in two consecutive cycles over all eight addresses. It judges each result against a reference model of owner and pending flags. It provokes the second by having the owner release while the pending side reads in the same cycle. The expected result is 8'hFF from the pre-write state, followed by 8'h00 on the next read.

// File: rtl/dpsem_pkg.sv
`timescale 1ns/1ps
package dpsem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpsem_port_dec.sv
`timescale 1ns/1ps
module dpsem_port_dec #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3
) (
  input  logic               sel,
  input  logic               we,
  input  logic               oe,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SEM-1:0] wr_vec,
  output logic               wr_bit,
  output logic               rd_en
);
  // Only bit 0 carries meaning; upper bits deliberately dropped.
  logic unused_hi_bits;
  assign unused_hi_bits = ^wdata[DATA_W-1:1];

  assign wr_bit = wdata[0];
  assign rd_en  = sel & oe & ~we;

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_wsel
    assign wr_vec[i] = sel & we & (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/dpsem_cell.sv
`timescale 1ns/1ps
module dpsem_cell
  import dpsem_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wl_en,
  input  logic   wl_bit,
  input  logic   wr_en,
  input  logic   wr_bit,
  output owner_e owner
);
  logic   req_l_q, req_r_q, req_l_d, req_r_d;
  owner_e own_q, own_d;

  always_comb begin
    req_l_d = wl_en ? ~wl_bit : req_l_q;
    req_r_d = wr_en ? ~wr_bit : req_r_q;
    if (own_q == OWN_LEFT && req_l_d)        own_d = OWN_LEFT;
    else if (own_q == OWN_RIGHT && req_r_d)  own_d = OWN_RIGHT;
    else if (req_l_d)                        own_d = OWN_LEFT;
    else if (req_r_d)                        own_d = OWN_RIGHT;
    else                                     own_d = OWN_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
      own_q   <= OWN_NONE;
    end else begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      own_q   <= own_d;
    end
  end

  assign owner = own_q;

  a_r1_untouched: assert property (@(posedge clk) disable iff (rst)
    (!wl_en && !wr_en) |=> $stable(owner));
  a_r4_owner_keeps: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && !(wl_en && wl_bit)) |=> owner == OWN_LEFT);
  a_r5_handover: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && req_r_q && wl_en && wl_bit && !(wr_en && wr_bit))
    |=> owner == OWN_RIGHT);
  a_r6_free_release: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && !req_r_q && wl_en && wl_bit && !(wr_en && !wr_bit))
    |=> owner == OWN_NONE);
  a_r7_left_wins: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_NONE && wl_en && !wl_bit && wr_en && !wr_bit)
    |=> (owner == OWN_LEFT && req_r_q));
  a_r10_reset_free: assert property (@(posedge clk)
    rst |=> (owner == OWN_NONE && !req_l_q && !req_r_q));
endmodule

// File: rtl/dpsem_rd_reg.sv
`timescale 1ns/1ps
module dpsem_rd_reg
  import dpsem_pkg::*;
#(
  parameter int NUM_SEM  = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter bit IS_RIGHT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  owner_e [NUM_SEM-1:0] own_vec,
  output logic [DATA_W-1:0]    rdata,
  output logic                 rvalid
);
  localparam owner_e MINE = IS_RIGHT ? OWN_RIGHT : OWN_LEFT;

  logic not_mine;
  assign not_mine = (own_vec[addr] != MINE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '1;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= {DATA_W{not_mine}};
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
  a_r8_uniform: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (rdata == '0 || rdata == '1));
endmodule

// File: rtl/dp_semaphore_bank.sv
`timescale 1ns/1ps
module dp_semaphore_bank
  import dpsem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic              r_sel,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid
);
  logic [NUM_SEM-1:0] l_wvec, r_wvec;
  logic               l_wbit, r_wbit, l_rd, r_rd;
  owner_e [NUM_SEM-1:0] owners;

  dpsem_port_dec #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec_l (
    .sel(l_sel), .we(l_we), .oe(l_oe), .addr(l_addr), .wdata(l_wdata),
    .wr_vec(l_wvec), .wr_bit(l_wbit), .rd_en(l_rd));

  dpsem_port_dec #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec_r (
    .sel(r_sel), .we(r_we), .oe(r_oe), .addr(r_addr), .wdata(r_wdata),
    .wr_vec(r_wvec), .wr_bit(r_wbit), .rd_en(r_rd));

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    dpsem_cell u_cell (
      .clk(clk), .rst(rst),
      .wl_en(l_wvec[i]), .wl_bit(l_wbit),
      .wr_en(r_wvec[i]), .wr_bit(r_wbit),
      .owner(owners[i]));
  end

  dpsem_rd_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IS_RIGHT(1'b0)) u_rd_l (
    .clk(clk), .rst(rst), .rd_en(l_rd), .addr(l_addr), .own_vec(owners),
    .rdata(l_rdata), .rvalid(l_rvalid));

  dpsem_rd_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IS_RIGHT(1'b1)) u_rd_r (
    .clk(clk), .rst(rst), .rd_en(r_rd), .addr(r_addr), .own_vec(owners),
    .rdata(r_rdata), .rvalid(r_rvalid));
endmodule

// File: tb/dp_semaphore_bank_test.sv
`timescale 1ns/1ps
module dp_semaphore_bank_test;
  localparam int IDLE = 0, WR = 1, RD = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic l_sel = 0, l_we = 0, l_oe = 0, r_sel = 0, r_we = 0, r_oe = 0;
  logic [2:0] l_addr = 0, r_addr = 0;
  logic [7:0] l_wdata = 0, r_wdata = 0, l_rdata, r_rdata;
  logic l_rvalid, r_rvalid;
  int n_tot = 0, n_fail = 0;

  // bench reference: 0 free, 1 left owns, 2 right owns
  int m_own[8];
  bit m_rl[8], m_rr[8];

  always #5 clk = ~clk;

  dp_semaphore_bank uut (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_sel(r_sel), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rvalid(r_rvalid));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int lc, input int la, input logic [7:0] ld,
                      input int rc, input int ra, input logic [7:0] rd);
    @(negedge clk);
    l_sel = (lc != IDLE); l_we = (lc == WR); l_oe = (lc == RD);
    l_addr = 3'(la); l_wdata = ld;
    r_sel = (rc != IDLE); r_we = (rc == WR); r_oe = (rc == RD);
    r_addr = 3'(ra); r_wdata = rd;
    @(posedge clk);
    #1;
  endtask

  // expected behaviour per R3..R7, R9 (a write of 0 sets a side's request, a 1 clears it)
  task automatic model_op(input int a, input int lop, input int rop);
    bit nl, nr;
    nl = (lop == 1) ? 1'b1 : (lop == 2) ? 1'b0 : m_rl[a];
    nr = (rop == 1) ? 1'b1 : (rop == 2) ? 1'b0 : m_rr[a];
    if (!(m_own[a] == 1 && nl) && !(m_own[a] == 2 && nr))
      m_own[a] = nl ? 1 : (nr ? 2 : 0);
    m_rl[a] = nl; m_rr[a] = nr;
  endtask

  task automatic apply(input int a, input int lop, input int rop);
    step(lop == 0 ? IDLE : WR, a, lop == 1 ? 8'h00 : 8'h01,
         rop == 0 ? IDLE : WR, a, rop == 1 ? 8'h00 : 8'h01);
    model_op(a, lop, rop);
  endtask

  task automatic read_both(input string req, input int a,
                           input logic [7:0] el, input logic [7:0] er);
    step(RD, a, 8'h00, RD, a, 8'h00);
    chk(req, l_rdata, el);
    chk(req, r_rdata, er);
  endtask

  initial begin
    #2_000_000;
    n_tot++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 rdata left", l_rdata, 8'hFF);
    chk("R10 rdata right", r_rdata, 8'hFF);
    chk("R10 rvalid", {6'd0, l_rvalid, r_rvalid}, 8'h00);
    @(negedge clk); rst = 1'b0;
    read_both("R10 free after reset", 5, 8'hFF, 8'hFF);

    // R3 grant, R4 denied, R5 handover, R6 free
    step(WR, 2, 8'h00, IDLE, 0, 0);
    read_both("R3 left grant", 2, 8'h00, 8'hFF);
    step(IDLE, 0, 0, WR, 2, 8'h00);
    read_both("R4 right denied", 2, 8'h00, 8'hFF);
    step(WR, 2, 8'h01, IDLE, 0, 0);
    read_both("R5 handover to right", 2, 8'hFF, 8'h00);
    step(IDLE, 0, 0, WR, 2, 8'h01);
    read_both("R6 free after release", 2, 8'hFF, 8'hFF);

    // R2 upper data bits ignored
    step(WR, 3, 8'hFE, IDLE, 0, 0);
    read_both("R2 FE requests", 3, 8'h00, 8'hFF);
    step(WR, 3, 8'h01, IDLE, 0, 0);
    read_both("R2 01 releases", 3, 8'hFF, 8'hFF);

    // R7 same-cycle contention
    step(WR, 4, 8'h00, WR, 4, 8'h00);
    read_both("R7 left wins", 4, 8'h00, 8'hFF);
    step(WR, 4, 8'h01, IDLE, 0, 0);
    read_both("R7 right pending then granted", 4, 8'hFF, 8'h00);
    step(IDLE, 0, 0, WR, 4, 8'h01);

    // R9 stray release, cancel of own pending request
    step(IDLE, 0, 0, WR, 5, 8'h01);
    read_both("R9 stray release on free", 5, 8'hFF, 8'hFF);
    step(WR, 5, 8'h00, IDLE, 0, 0);
    step(IDLE, 0, 0, WR, 5, 8'h01);
    read_both("R9 stray release on owned", 5, 8'h00, 8'hFF);
    step(IDLE, 0, 0, WR, 5, 8'h00);
    step(IDLE, 0, 0, WR, 5, 8'h01);
    step(WR, 5, 8'h01, IDLE, 0, 0);
    read_both("R9 cancelled request not granted", 5, 8'hFF, 8'hFF);

    // R8 hold and valid pulse
    step(WR, 6, 8'h00, IDLE, 0, 0);
    step(RD, 6, 8'h00, IDLE, 0, 0);
    chk("R8 read value", l_rdata, 8'h00);
    chk("R8 rvalid high", {7'd0, l_rvalid}, 8'h01);
    step(IDLE, 0, 0, WR, 6, 8'h00);
    chk("R8 rvalid drops", {7'd0, l_rvalid}, 8'h00);
    step(WR, 6, 8'h01, IDLE, 0, 0);
    chk("R8 held despite ownership change", l_rdata, 8'h00);
    step(IDLE, 0, 0, WR, 6, 8'h01);

    // R11 read against same-cycle opposite write
    step(WR, 7, 8'h00, IDLE, 0, 0);
    step(IDLE, 0, 0, WR, 7, 8'h00);
    step(WR, 7, 8'h01, RD, 7, 8'h00);
    chk("R11 pre-write value", r_rdata, 8'hFF);
    step(IDLE, 0, 0, RD, 7, 8'h00);
    chk("R11 next read updated", r_rdata, 8'h00);
    step(IDLE, 0, 0, WR, 7, 8'h01);

    // sweep: every address, every two-cycle pair of operations (R1 R3 R4 R5 R6 R7 R9)
    for (int a = 0; a < 8; a++) begin
      for (int k = 0; k < 81; k++) begin
        int b;
        b = (a + 3) % 8;
        step(WR, a, 8'h01, WR, a, 8'h01);
        m_own[a] = 0; m_rl[a] = 0; m_rr[a] = 0;
        apply(a, k % 3, (k / 3) % 3);
        apply(a, (k / 9) % 3, (k / 27) % 3);
        read_both("R3 R4 R5 R6 R7 R9 sweep", a,
                  (m_own[a] == 1) ? 8'h00 : 8'hFF,
                  (m_own[a] == 2) ? 8'h00 : 8'hFF);
        read_both("R1 other address untouched", b, 8'hFF, 8'hFF);
      end
    end

    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule